// File: doc/BRIEF.md
# Dual Row Delay Line for a 3x3 Window

This block feeds a 3x3 image window from a raster pixel stream. Each accepted pixel enters the first of two equal delay lines. The first line feeds the second. Both lines share one programmable length N of 1 to 1024 stages, which is normally the image row width. The block registers three taps: the current pixel, the pixel from one row earlier and the pixel from two rows earlier. It also drives a cascade stream, which is the input delayed by two rows, so that a second block can continue the chain.

Pixels arrive on a valid/ready stream. A beat is accepted on a clock edge where `pix_valid` and `pix_ready` are both high. `pix_ready` is low whenever `hold` or `frame_clr` is high. A source that sees ready low must keep its beat until ready returns. Nothing advances during such a cycle. The output side has no back-pressure: `tap_valid` pulses for one cycle for each accepted beat.

The row length register can be written once per reset. If no write arrives soon enough after reset, the register locks at its default of 0, which means the full 1024 stages. A frame clear empties the window. The bypass control takes the two older rows from external inputs instead of from the internal lines.

Top module: `row_delay_pair`

## Requirements
- R1: On the clock edge that accepts a beat, `tap0` takes the accepted pixel and `tap_valid` goes high for that one cycle. `tap_valid` is low after any edge that accepts no beat.
- R2: A length write carries the row length in `len_data[9:0]`. Values 1 to 1023 give N equal to that value, and 0 gives N = 1024. `row_len` shows the stored value from the edge after the write.
- R3: The first accepted length write sets `len_locked`. Every later write leaves `row_len` unchanged until `rst_n` is asserted again.
- R4: The register may be left unwritten through the first 1024 clock edges after `rst_n` goes high. In that case it locks with value 0 and later writes are ignored. A write presented on the 1024th edge is still accepted.
- R5: For the beat accepted as number k since reset or the last frame clear (counting from 0), `tap1` takes beat k-N and `tap2` takes beat k-2N. A tap reads 0 while that older beat does not exist. N of 1 and 2 are legal.
- R6: `casc_out` takes beat k-2N of the internal chain, or 0 while that beat does not exist. This holds whatever the bypass setting.
- R7: While `bypass` is 1, `tap1` and `tap2` take `ext_row1` and `ext_row2` on each accepted beat. The internal lines keep storing and advancing.
- R8: While `hold` is 1, `pix_ready` is 0, no beat is accepted, and the taps, `casc_out` and the line positions stay unchanged.
- R9: While `frame_clr` is 1, `pix_ready` is 0. After that edge all taps and `casc_out` read 0, `tap_valid` is 0, and the stored rows count as empty, so old contents never reach a tap.
- R10: `primed` goes high once 2N beats have been accepted since reset or the last frame clear. It is low after reset and after a frame clear.
- R11: After reset, all taps, `casc_out`, `tap_valid`, `row_len`, `len_locked` and `primed` are 0, and `pix_ready` is 1 when `hold` and `frame_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | Pixel beat offered |
| pix_ready | output | 1 | Beat can be taken this cycle |
| pix_data | input | 8 | Pixel value |
| hold | input | 1 | Freeze the stream and line positions |
| frame_clr | input | 1 | Start of frame: empty the window |
| len_wr | input | 1 | Row length write strobe |
| len_data | input | 10 | Row length value (0 means 1024) |
| bypass | input | 1 | Older rows taken from external inputs |
| ext_row1 | input | 8 | External one-row-old pixel |
| ext_row2 | input | 8 | External two-row-old pixel |
| tap0 | output | 8 | Current pixel |
| tap1 | output | 8 | Pixel one row old |
| tap2 | output | 8 | Pixel two rows old |
| tap_valid | output | 1 | Taps updated by an accepted beat |
| casc_out | output | 8 | Input delayed by two rows |
| row_len | output | 10 | Stored row length value |
| len_locked | output | 1 | Length register is locked |
| primed | output | 1 | Two full rows have entered |

## Verification
The taps, `casc_out` and `tap_valid` are registered at the same edge that accepts a beat, so each is due one clock after the beat is driven. `row_len`, `len_locked` and `primed` change at the write edge or the accepting edge and are due at that same delay. `pix_ready` is combinational from `hold` and `frame_clr` and is checked in the same cycle, before the edge. The bench drives every input on the falling edge and samples on the next falling edge. A reference history of accepted beats gives the expected k-N and k-2N values. The auto-lock window is checked by counting edges from reset release exactly at 1023 and at 1024.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  localparam int PIX_W_DEF   = 8;
  localparam int MAX_LEN_DEF = 1024;
  localparam int AUTO_DEF    = 1024;
  localparam int NLINES      = 2;
endpackage

// File: rtl/rdl_len_reg.sv
module rdl_len_reg #(
  parameter int LEN_W      = 10,
  parameter int AUTO_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] row_len,
  output logic             locked
);
  localparam int TW = $clog2(AUTO_LIMIT + 1);
  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_len <= '0;
      locked  <= 1'b0;
      timer   <= '0;
    end else if (!locked) begin
      timer <= timer + 1'b1;
      if (wr) begin
        row_len <= wdata;
        locked  <= 1'b1;
      end else if (timer == TW'(AUTO_LIMIT - 1)) begin
        row_len <= '0;
        locked  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdl_fill.sv
module rdl_fill #(
  parameter int LEN_W  = 10,
  parameter int NLINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [LEN_W-1:0]  row_len,
  output logic [LEN_W-1:0]  ptr,
  output logic [NLINES-1:0] line_ok,
  output logic              primed
);
  localparam int CW = LEN_W + 2;
  localparam logic [LEN_W:0] FULL = {1'b1, {LEN_W{1'b0}}};

  logic [LEN_W:0] n_eff;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  span [NLINES];

  assign n_eff = (row_len == '0) ? FULL : {1'b0, row_len};

  for (genvar g = 0; g < NLINES; g++) begin : g_span
    assign span[g]    = CW'(n_eff) * CW'(g + 1);
    assign line_ok[g] = (cnt >= span[g]);
  end

  assign primed = line_ok[NLINES-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr <= '0;
      cnt <= '0;
    end else if (adv) begin
      if ({1'b0, ptr} >= n_eff - 1'b1) ptr <= '0;
      else                             ptr <= ptr + 1'b1;
      if (cnt < span[NLINES-1]) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rdl_line.sv
module rdl_line #(
  parameter int PIX_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LEN_W-1:0] addr,
  input  logic [PIX_W-1:0] din,
  input  logic             ok,
  output logic [PIX_W-1:0] dout
);
  localparam int DEPTH = 1 << LEN_W;
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
  end

  assign dout = ok ? mem[addr] : '0;
endmodule

// File: rtl/row_delay_pair.sv
module row_delay_pair
  import rdl_pkg::*;
#(
  parameter int PIX_W      = PIX_W_DEF,
  parameter int MAX_LEN    = MAX_LEN_DEF,
  parameter int AUTO_LIMIT = AUTO_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_valid,
  output logic                       pix_ready,
  input  logic [PIX_W-1:0]           pix_data,
  input  logic                       hold,
  input  logic                       frame_clr,
  input  logic                       len_wr,
  input  logic [$clog2(MAX_LEN)-1:0] len_data,
  input  logic                       bypass,
  input  logic [PIX_W-1:0]           ext_row1,
  input  logic [PIX_W-1:0]           ext_row2,
  output logic [PIX_W-1:0]           tap0,
  output logic [PIX_W-1:0]           tap1,
  output logic [PIX_W-1:0]           tap2,
  output logic                       tap_valid,
  output logic [PIX_W-1:0]           casc_out,
  output logic [$clog2(MAX_LEN)-1:0] row_len,
  output logic                       len_locked,
  output logic                       primed
);
  localparam int LEN_W = $clog2(MAX_LEN);

  logic              adv;
  logic [LEN_W-1:0]  ptr;
  logic [NLINES-1:0] line_ok;
  logic [PIX_W-1:0]  line_in  [NLINES];
  logic [PIX_W-1:0]  line_out [NLINES];

  assign pix_ready = ~hold & ~frame_clr;
  assign adv       = pix_valid & pix_ready;

  rdl_len_reg #(.LEN_W(LEN_W), .AUTO_LIMIT(AUTO_LIMIT)) u_len (
    .clk(clk), .rst_n(rst_n), .wr(len_wr), .wdata(len_data),
    .row_len(row_len), .locked(len_locked)
  );

  rdl_fill #(.LEN_W(LEN_W), .NLINES(NLINES)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .adv(adv),
    .row_len(row_len), .ptr(ptr), .line_ok(line_ok), .primed(primed)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    if (g == 0) begin : g_head
      assign line_in[g] = pix_data;
    end else begin : g_tail
      assign line_in[g] = line_out[g-1];
    end
    rdl_line #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_line (
      .clk(clk), .we(adv), .addr(ptr), .din(line_in[g]),
      .ok(line_ok[g]), .dout(line_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_clr) begin
      tap0      <= '0;
      tap1      <= '0;
      tap2      <= '0;
      casc_out  <= '0;
      tap_valid <= 1'b0;
    end else begin
      tap_valid <= adv;
      if (adv) begin
        tap0     <= pix_data;
        tap1     <= bypass ? ext_row1 : line_out[0];
        tap2     <= bypass ? ext_row2 : line_out[NLINES-1];
        casc_out <= line_out[NLINES-1];
      end
    end
  end
endmodule

// File: rtl/rdl_checker.sv
module rdl_checker #(
  parameter int PIX_W      = 8,
  parameter int LEN_W      = 10,
  parameter int AUTO_LIMIT = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             hold,
  input logic             frame_clr,
  input logic [PIX_W-1:0] tap0,
  input logic [PIX_W-1:0] tap1,
  input logic [PIX_W-1:0] tap2,
  input logic             tap_valid,
  input logic [PIX_W-1:0] casc_out,
  input logic [LEN_W-1:0] row_len,
  input logic             len_locked,
  input logic             primed
);
  localparam int TW = $clog2(AUTO_LIMIT + 1);
  logic [TW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)                         since <= '0;
    else if (since != TW'(AUTO_LIMIT))  since <= since + 1'b1;
  end

  p_valid_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |-> $past(pix_valid && pix_ready));

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    len_locked |=> len_locked);

  p_len_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    len_locked |=> $stable(row_len));

  p_auto_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since == TW'(AUTO_LIMIT)) |-> len_locked);

  p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !frame_clr) |=> (!tap_valid && $stable(tap0) && $stable(tap1)
                              && $stable(tap2) && $stable(casc_out)));

  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (tap0 == '0 && tap1 == '0 && tap2 == '0 && casc_out == '0
                   && !tap_valid && !primed));

  p_primed_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && len_locked && !frame_clr) |=> primed);
endmodule

bind row_delay_pair rdl_checker #(
  .PIX_W(PIX_W), .LEN_W(LEN_W), .AUTO_LIMIT(AUTO_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .hold(hold), .frame_clr(frame_clr), .tap0(tap0), .tap1(tap1), .tap2(tap2),
  .tap_valid(tap_valid), .casc_out(casc_out), .row_len(row_len),
  .len_locked(len_locked), .primed(primed)
);

// File: tb/sim_row_delay_pair.sv
module sim_row_delay_pair;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [9:0]  len;
    logic [15:0] beats;
    logic        primed;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{10'd5, 16'd9,    1'b0},
    '{10'd5, 16'd10,   1'b1},
    '{10'd1, 16'd4,    1'b1},
    '{10'd2, 16'd3,    1'b0},
    '{10'd3, 16'd8,    1'b1},
    '{10'd0, 16'd2050, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n, pix_valid, hold, frame_clr, len_wr, bypass;
  logic [7:0] pix_data, ext_row1, ext_row2;
  logic [9:0] len_data;
  logic       pix_ready, tap_valid, len_locked, primed;
  logic [7:0] tap0, tap1, tap2, casc_out;
  logic [9:0] row_len;

  int checks = 0;
  int fails  = 0;
  int hist [4096];
  int k, n, e0, e1, e2, ec;
  bit byp;

  always #(CLK_P/2) clk = ~clk;

  row_delay_pair u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .hold(hold), .frame_clr(frame_clr), .len_wr(len_wr),
    .len_data(len_data), .bypass(bypass), .ext_row1(ext_row1),
    .ext_row2(ext_row2), .tap0(tap0), .tap1(tap1), .tap2(tap2),
    .tap_valid(tap_valid), .casc_out(casc_out), .row_len(row_len),
    .len_locked(len_locked), .primed(primed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix_valid = 1'b0; hold = 1'b0; frame_clr = 1'b0;
    len_wr = 1'b0; bypass = 1'b0; pix_data = '0; ext_row1 = '0;
    ext_row2 = '0; len_data = '0;
    byp = 1'b0; k = 0; n = 1024; e0 = 0; e1 = 0; e2 = 0; ec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_len(input int v);
    len_wr = 1'b1; len_data = 10'(v);
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  task automatic beat(input int p, input bit h);
    pix_valid = 1'b1; pix_data = 8'(p); hold = h;
    ext_row1 = 8'(p) ^ 8'h5A; ext_row2 = ~8'(p);
    #1;
    if (h) chk("R8 ready", pix_ready, 0);
    @(negedge clk);
    if (h) begin
      chk("R8 valid", tap_valid, 0);
      chk("R8 tap0", tap0, e0);
      chk("R8 tap1", tap1, e1);
      chk("R8 tap2", tap2, e2);
      chk("R8 casc", casc_out, ec);
    end else begin
      hist[k] = p & 255;
      e0 = p & 255;
      ec = (k >= 2*n) ? hist[k-2*n] : 0;
      e1 = byp ? int'(ext_row1) : ((k >= n) ? hist[k-n] : 0);
      e2 = byp ? int'(ext_row2) : ec;
      k++;
      chk("R1 valid", tap_valid, 1);
      chk("R1 tap0", tap0, e0);
      chk(byp ? "R7 tap1" : "R5 tap1", tap1, e1);
      chk(byp ? "R7 tap2" : "R5 tap2", tap2, e2);
      chk("R6 casc", casc_out, ec);
    end
    pix_valid = 1'b0; hold = 1'b0;
  endtask

  task automatic set_len(input int v);
    wr_len(v);
    n = (v == 0) ? 1024 : v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // table walk: R2, R5, R6, R10 over several lengths
    for (int s = 0; s < 6; s++) begin
      do_reset();
      set_len(int'(VEC[s].len));
      chk("R2 row_len", row_len, VEC[s].len);
      chk("R3 locked", len_locked, 1);
      for (int i = 0; i < int'(VEC[s].beats); i++) begin
        if (i % 7 == 3) beat(i * 13 + 1, 1'b1);
        beat(i * 37 + s * 11 + 5, 1'b0);
      end
      chk("R10 primed", primed, VEC[s].primed);
    end

    // R11 reset state
    do_reset();
    #1;
    chk("R11 tap0", tap0, 0);
    chk("R11 tap1", tap1, 0);
    chk("R11 tap2", tap2, 0);
    chk("R11 casc", casc_out, 0);
    chk("R11 valid", tap_valid, 0);
    chk("R11 row_len", row_len, 0);
    chk("R11 locked", len_locked, 0);
    chk("R11 primed", primed, 0);
    chk("R11 ready", pix_ready, 1);

    // R3 second write ignored, delay follows the first value
    do_reset();
    set_len(4);
    wr_len(9);
    chk("R3 row_len", row_len, 4);
    for (int i = 0; i < 12; i++) beat(i * 19 + 7, 1'b0);
    chk("R10 primed", primed, 1);

    // R4 auto-lock boundaries
    do_reset();
    repeat (1023) @(negedge clk);
    chk("R4 unlocked", len_locked, 0);
    wr_len(6);
    chk("R4 late ok", row_len, 6);
    do_reset();
    repeat (1024) @(negedge clk);
    chk("R4 locked", len_locked, 1);
    chk("R4 value", row_len, 0);
    wr_len(6);
    chk("R4 ignored", row_len, 0);

    // R9 frame clear
    do_reset();
    set_len(3);
    for (int i = 0; i < 8; i++) beat(i * 23 + 3, 1'b0);
    frame_clr = 1'b1; pix_valid = 1'b1; pix_data = 8'd77;
    #1;
    chk("R9 ready", pix_ready, 0);
    @(negedge clk);
    frame_clr = 1'b0; pix_valid = 1'b0;
    chk("R9 tap0", tap0, 0);
    chk("R9 tap1", tap1, 0);
    chk("R9 tap2", tap2, 0);
    chk("R9 casc", casc_out, 0);
    chk("R9 valid", tap_valid, 0);
    chk("R10 primed clr", primed, 0);
    k = 0; e0 = 0; e1 = 0; e2 = 0; ec = 0;
    for (int i = 0; i < 7; i++) beat(i * 41 + 9, 1'b0);

    // R7 bypass, then back to internal lines
    do_reset();
    set_len(3);
    byp = 1'b1; bypass = 1'b1;
    for (int i = 0; i < 9; i++) beat(i * 29 + 2, 1'b0);
    byp = 1'b0; bypass = 1'b0;
    for (int i = 0; i < 4; i++) beat(i * 31 + 4, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule